// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one burst access inside a bank row of 256 columns. A read or write command loads a starting column. From the next cycle on, the block presents one column per clock in which clock enable is high. The burst runs for a length of 1, 2, 4 or 8 columns, or for a whole page. Fixed-length bursts stay inside the aligned block whose size is the burst length. Inside that block they step either upward with wrap-around or by XOR of a counter with the low start bits. A full-page burst counts upward through the row and wraps from the top column back to zero. It ends only on a burst stop or a new command.

The block marks the last column of a fixed-length burst. If the command asked for auto-precharge, it raises a one-cycle precharge request after the burst ends naturally. A burst-stop input ends a burst early. A new command restarts the sequence at once. Holding clock enable low freezes the whole sequence. An option shortens write bursts to a single column while reads keep the programmed length. The mode settings are captured when the command is accepted.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid, col_last and precharge_req are all 0.
- R2: A cmd_valid sampled on a clock edge with clk_en high starts a burst. From the next cycle col_valid is 1 and col_addr equals cmd_col.
- R3: mode_len selects the burst length L: 0 gives 1 column, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives a full page, and 4 to 6 give 1 column. A fixed burst presents exactly L columns and raises col_last on the final one only. col_valid is 0 in the cycle after the final column.
- R4: With mode_interleave=0, column n of a fixed burst is (start & ~(L-1)) | ((start + n) & (L-1)).
- R5: With mode_interleave=1, column n of a fixed burst is (start & ~(L-1)) | ((start ^ n) & (L-1)).
- R6: A full-page burst presents (start + n) mod 256 whatever the order setting. It never raises col_last and it continues until a burst stop or a new command.
- R7: burst_stop on an enabled edge during a burst, without cmd_valid, makes col_valid 0 from the next cycle and raises no precharge request.
- R8: On an edge where clk_en is 0, all state holds: col_addr, col_valid, col_last and precharge_req keep their values, and cmd_valid and burst_stop are ignored.
- R9: When mode_single_write=1, a write command (cmd_write=1) gives a 1-column burst for every mode_len. Reads keep the programmed length.
- R10: If cmd_autopre was 1 with the command, precharge_req is 1 for the single enabled cycle after the edge that retires the last column. It stays 0 after a stop and when a new command is accepted on that edge.
- R11: cmd_valid during a burst reloads the sequencer on the same edge, with priority over burst_stop. The old burst's auto-precharge is dropped.
- R12: mode_len, mode_interleave and mode_single_write are captured with the command. Changing them during a burst does not change its columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the sequencer |
| cmd_valid | input | 1 | Read or write command with start column |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | COL_W | Starting column |
| cmd_autopre | input | 1 | Request precharge at burst end |
| burst_stop | input | 1 | Terminate the current burst |
| mode_len | input | 3 | Burst length code |
| mode_interleave | input | 1 | 1 = XOR order, 0 = linear order |
| mode_single_write | input | 1 | Writes use single-column bursts |
| col_valid | output | 1 | A column is presented this cycle |
| col_addr | output | COL_W | Current column address |
| col_last | output | 1 | Final column of a fixed burst |
| precharge_req | output | 1 | One-cycle auto-precharge request |

## Verification
The bench runs every start column through every fixed length in both orders and compares each column against arithmetic. A design that wraps across the aligned-block boundary, or that mixes up the XOR and add paths, shows a wrong address at the block edge or on unaligned starts. Further checks target the full-page wrap from 255 to 0 and a stop that must not raise a precharge. A command landing on the last column must discard the old precharge, and mode changes made mid-burst must not be taken up. A frozen clock enable must ignore a command and a stop and must hold a pending precharge pulse; a design that counts through the pause or drops the pulse is reported.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_CODE_PAGE = 3'd7;
    localparam int MAX_FIXED_LOG = 3;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  single_wr,
    input  logic                  is_write,
    output logic [COL_W-1:0]      blk_mask,
    output logic                  full_page
);
    logic [COL_W-1:0] raw_mask;
    logic             fixed_ok;
    logic             force_one;

    assign fixed_ok  = (32'(len_code) <= MAX_FIXED_LOG);
    assign force_one = single_wr && is_write;

    for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
        assign raw_mask[gi] = (32'(len_code) > gi);
    end

    always_comb begin
        full_page = 1'b0;
        blk_mask  = '0;
        if (force_one) begin
            blk_mask = '0;
        end else if (len_code == LEN_CODE_PAGE) begin
            full_page = 1'b1;
            blk_mask  = '1;
        end else if (fixed_ok) begin
            blk_mask = raw_mask;
        end
        // R3: the block mask is always a run of low ones
        p_mask_contig_r3: assert (((blk_mask + COL_W'(1)) & blk_mask) == '0);
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] step_cnt,
    input  logic [COL_W-1:0] blk_mask,
    input  order_e           order,
    output logic [COL_W-1:0] col_out
);
    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_val;
    logic [COL_W-1:0] low_sel;

    assign lin_sum = start_col + step_cnt;
    assign xor_val = start_col ^ step_cnt;
    assign low_sel = (order == ORD_XOR) ? xor_val : lin_sum;

    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        assign col_out[gi] = blk_mask[gi] ? low_sel[gi] : start_col[gi];
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en,
    input  logic                  cmd_valid,
    input  logic                  cmd_write,
    input  logic [COL_W-1:0]      cmd_col,
    input  logic                  cmd_autopre,
    input  logic                  burst_stop,
    input  logic [LEN_CODE_W-1:0] mode_len,
    input  logic                  mode_interleave,
    input  logic                  mode_single_write,
    output logic                  col_valid,
    output logic [COL_W-1:0]      col_addr,
    output logic                  col_last,
    output logic                  precharge_req
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
        logic             full;
        order_e           ord;
        logic             autopre;
        logic             pre_req;
    } seq_t;

    seq_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             at_last;

    bcs_len_dec #(.COL_W(COL_W)) u_len (
        .len_code  (mode_len),
        .single_wr (mode_single_write),
        .is_write  (cmd_write),
        .blk_mask  (dec_mask),
        .full_page (dec_full)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .start_col (st_q.start),
        .step_cnt  (st_q.cnt),
        .blk_mask  (st_q.mask),
        .order     (st_q.ord),
        .col_out   (col_addr)
    );

    assign at_last = st_q.active && !st_q.full && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.pre_req = 1'b0;
            if (cmd_valid) begin
                st_d.active  = 1'b1;
                st_d.start   = cmd_col;
                st_d.cnt     = '0;
                st_d.mask    = dec_mask;
                st_d.full    = dec_full;
                st_d.ord     = (mode_interleave && !dec_full) ? ORD_XOR : ORD_LINEAR;
                st_d.autopre = cmd_autopre;
            end else if (st_q.active) begin
                if (burst_stop) begin
                    st_d.active = 1'b0;
                end else if (at_last) begin
                    st_d.active  = 1'b0;
                    st_d.pre_req = st_q.autopre;
                end else begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, start: '0, cnt: '0, mask: '0, full: 1'b0,
                      ord: ORD_LINEAR, autopre: 1'b0, pre_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign col_valid     = st_q.active;
    assign col_last      = at_last;
    assign precharge_req = st_q.pre_req;

    // R2: accepted command shows its start column next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd_valid) |=> (col_valid && col_addr == $past(cmd_col)));

    // R4/R5: fixed bursts stay inside the aligned block
    p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !st_q.full) |-> (((col_addr ^ st_q.start) & ~st_q.mask) == '0));

    // R6: full page steps by one modulo the row
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cmd_valid && !burst_stop && col_valid && st_q.full)
        |=> (col_addr == $past(col_addr) + COL_W'(1)));

    // R7: stop ends the burst with no precharge
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cmd_valid && burst_stop && col_valid) |=> (!col_valid && !precharge_req));

    // R8: frozen while clock enable is low
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> ($stable(col_addr) && $stable(col_valid) && $stable(precharge_req)));

    // R10: natural end with auto-precharge raises the request
    p_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cmd_valid && !burst_stop && col_last && st_q.autopre) |=> precharge_req);

    // R10: request lasts one enabled cycle
    p_pre_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && precharge_req) |=> !precharge_req);
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = '0;
    logic       cmd_autopre = 1'b0;
    logic       burst_stop = 1'b0;
    logic [2:0] mode_len = '0;
    logic       mode_interleave = 1'b0;
    logic       mode_single_write = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       col_last;
    logic       precharge_req;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(8)) uut (
        .clk, .rst_n, .clk_en, .cmd_valid, .cmd_write, .cmd_col, .cmd_autopre,
        .burst_stop, .mode_len, .mode_interleave, .mode_single_write,
        .col_valid, .col_addr, .col_last, .precharge_req
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expc(int s, int n, int k, bit ilv, bit full);
        int blk, base, off;
        if (full) return (s + n) % 256;
        blk  = 1 << k;
        base = s - (s % blk);
        off  = ilv ? ((s % blk) ^ n) : (((s % blk) + n) % blk);
        return base + off;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(int col, int code, bit ilv, bit wr, bit ap);
        cmd_valid = 1'b1; cmd_col = 8'(col); mode_len = 3'(code);
        mode_interleave = ilv; cmd_write = wr; cmd_autopre = ap;
        step();
        cmd_valid = 1'b0; cmd_autopre = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        chk("R1 valid in reset", int'(col_valid), 0);
        chk("R1 precharge in reset", int'(precharge_req), 0);
        rst_n = 1'b1;
        step(); step();
        chk("R1 valid after reset", int'(col_valid), 0);
        chk("R1 last after reset", int'(col_last), 0);
        chk("R1 precharge after reset", int'(precharge_req), 0);

        // R3 R4 R5 R10: sweep of all starts, fixed lengths and both orders
        for (int code = 0; code < 4; code++) begin
            for (int o = 0; o < 2; o++) begin
                for (int s = 0; s < 256; s++) begin
                    bit ap;
                    ap = s[0];
                    issue(s, code, o[0], 1'b0, ap);
                    for (int n = 0; n < (1 << code); n++) begin
                        chk(o[0] ? "R5 xor column" : "R4 linear column",
                            int'(col_addr), expc(s, n, code, o[0], 1'b0));
                        chk("R2 R3 valid during burst", int'(col_valid), 1);
                        chk("R3 last flag", int'(col_last), int'(n == (1 << code) - 1));
                        step();
                    end
                    chk("R3 ended after L columns", int'(col_valid), 0);
                    chk("R10 precharge at end", int'(precharge_req), int'(ap));
                    step();
                    chk("R10 precharge one cycle", int'(precharge_req), 0);
                end
            end
        end

        // R3: reserved length code acts as one column
        issue(9, 5, 1'b0, 1'b0, 1'b0);
        chk("R3 reserved code column", int'(col_addr), 9);
        chk("R3 reserved code last", int'(col_last), 1);
        step();
        chk("R3 reserved code ended", int'(col_valid), 0);

        // R6: full page wraps and runs until stop
        issue(250, 7, 1'b1, 1'b0, 1'b1);
        for (int n = 0; n < 300; n++) begin
            chk("R6 full page column", int'(col_addr), expc(250, n, 0, 1'b0, 1'b1));
            chk("R6 full page no last", int'(col_last), 0);
            step();
        end
        chk("R6 full page still running", int'(col_valid), 1);
        burst_stop = 1'b1;
        step();
        burst_stop = 1'b0;
        chk("R7 stop ends full page", int'(col_valid), 0);
        chk("R7 no precharge on stop", int'(precharge_req), 0);

        // R7: stop inside a fixed burst with auto-precharge
        issue(8, 3, 1'b0, 1'b0, 1'b1);
        step();
        chk("R7 second column", int'(col_addr), 9);
        burst_stop = 1'b1;
        step();
        burst_stop = 1'b0;
        chk("R7 stopped early", int'(col_valid), 0);
        chk("R7 stop precharge", int'(precharge_req), 0);
        step();
        chk("R7 stop precharge later", int'(precharge_req), 0);

        // R8: clock enable freeze
        issue(16, 3, 1'b0, 1'b0, 1'b1);
        step();
        clk_en = 1'b0; cmd_valid = 1'b1; cmd_col = 8'd100; burst_stop = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 address frozen", int'(col_addr), 17);
            chk("R8 valid frozen", int'(col_valid), 1);
        end
        clk_en = 1'b1; cmd_valid = 1'b0; burst_stop = 1'b0;
        for (int n = 2; n < 8; n++) begin
            step();
            chk("R8 resumes", int'(col_addr), 16 + n);
        end
        step();
        chk("R10 precharge after frozen burst", int'(precharge_req), 1);
        clk_en = 1'b0;
        step();
        chk("R8 precharge held", int'(precharge_req), 1);
        clk_en = 1'b1;
        step();
        chk("R10 precharge released", int'(precharge_req), 0);

        // R9: single-column writes
        mode_single_write = 1'b1;
        issue(40, 3, 1'b0, 1'b1, 1'b1);
        chk("R9 write column", int'(col_addr), 40);
        chk("R9 write last", int'(col_last), 1);
        step();
        chk("R9 write ended", int'(col_valid), 0);
        chk("R9 write precharge", int'(precharge_req), 1);
        issue(3, 7, 1'b0, 1'b1, 1'b0);
        chk("R9 full page write last", int'(col_last), 1);
        step();
        chk("R9 full page write ended", int'(col_valid), 0);
        issue(40, 3, 1'b0, 1'b0, 1'b0);
        for (int n = 0; n < 7; n++) step();
        chk("R9 read keeps length", int'(col_addr), 47);
        chk("R9 read last", int'(col_last), 1);
        step();
        mode_single_write = 1'b0;

        // R11: reload mid-burst beats stop and drops old precharge
        issue(0, 3, 1'b0, 1'b0, 1'b1);
        step();
        cmd_valid = 1'b1; cmd_col = 8'd200; mode_len = 3'd1; burst_stop = 1'b1; cmd_autopre = 1'b0;
        step();
        cmd_valid = 1'b0; burst_stop = 1'b0;
        chk("R11 reload column", int'(col_addr), 200);
        chk("R11 reload valid", int'(col_valid), 1);
        step();
        chk("R11 reload second", int'(col_addr), 201);
        chk("R11 reload last", int'(col_last), 1);
        step();
        chk("R11 old precharge dropped", int'(precharge_req), 0);

        // R10: new command on the last column suppresses the request
        issue(5, 0, 1'b0, 1'b0, 1'b1);
        cmd_valid = 1'b1; cmd_col = 8'd77; mode_len = 3'd0; cmd_autopre = 1'b0;
        step();
        cmd_valid = 1'b0;
        chk("R10 no precharge on overlap", int'(precharge_req), 0);
        chk("R11 overlap column", int'(col_addr), 77);
        step();

        // R12: mode changes during a burst are ignored
        issue(10, 2, 1'b1, 1'b0, 1'b0);
        mode_len = 3'd7; mode_interleave = 1'b0; mode_single_write = 1'b1;
        for (int n = 0; n < 4; n++) begin
            chk("R12 captured order", int'(col_addr), expc(10, n, 2, 1'b1, 1'b0));
            step();
        end
        chk("R12 captured length", int'(col_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule